// File: doc/BRIEF.md
# Clock and Frame Sync Generator

This block turns an incoming source clock into a serial bit clock and a frame synchronization pulse for serial audio and data ports. A fast system clock samples the source clock. Each rising edge of the sampled source level is one source tick, and all counting advances on ticks. A bit divisor sets the bit clock period in ticks. A frame divisor sets how many bit clock periods make one frame. A phase value sets which bit clock period within the frame carries the frame pulse.

Small divisor values select pass-through variants. A bit divisor of 0 or 1 makes the bit clock follow the sampled source level. A frame divisor of 0 or 1 makes the frame output follow an external frame input instead of the internal counter. A loop request input would select the block's own bit clock as its source. That choice is refused, and the source is tied low instead. Dropping the enable clears both counters. Every enable therefore starts the bit clock and the frame count together from zero.

Top module: `clkfs_gen`

## Requirements
- R1: With `clk_div` >= 2 the bit clock has a period of `clk_div` ticks and is high for the first floor(`clk_div`/2) ticks of each period. A tick is a 0-to-1 change of the sampled source level. The bit clock changes only in the cycle after a tick. The exception is enable, which sets the bit clock high in the cycle after `enable` is sampled high.
- R2: For an odd `clk_div` the bit clock low time is exactly one tick longer than its high time. For example, `clk_div` = 5 gives 2 ticks high and 3 ticks low.
- R3: With `clk_div` of 0 or 1, `bclk_o` equals the value of (`src_clk` AND NOT `src_loop`) sampled one system clock earlier. The frame counter then advances on every tick.
- R4: With `frm_div` >= 2, `fsync_o` is high for exactly one bit clock period in every `frm_div` bit clock periods. That is the period whose frame count equals the phase. The frame count is 0 for the first bit clock period after enable and steps at each bit clock period start. A rising `fsync_o` coincides with a rising `bclk_o`.
- R5: A phase value at or above `frm_div` acts as `frm_phase` modulo `frm_div`.
- R6: With `frm_div` of 0 or 1, `fsync_o` equals `fs_ext` sampled one system clock earlier.
- R7: While `src_loop` is high the source is held at logic low. No ticks occur, and in pass-through mode `bclk_o` is low.
- R8: While `enable` is low, both outputs are low from the next cycle on and both counters are held at zero. Reset puts both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the source |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low clears counters and outputs |
| src_clk | input | 1 | Source clock level to be divided |
| src_loop | input | 1 | Request to use own bit clock as source; forces source low |
| fs_ext | input | 1 | External frame sync used in frame bypass |
| clk_div | input | 20 | Bit clock divisor in ticks; 0 or 1 selects pass-through |
| frm_div | input | 20 | Bit clock periods per frame; 0 or 1 selects bypass |
| frm_phase | input | 20 | Bit clock period in the frame that carries the pulse |
| bclk_o | output | 1 | Divided bit clock |
| fsync_o | output | 1 | Frame synchronization output |

## Verification
A corrupted bit counter shows on `bclk_o` within one bit clock period, as a wrong high or low run length. A corrupted frame counter shifts or repeats the `fsync_o` pulse and is visible within one frame. A wrong mode decode or wrong phase reduction changes `fsync_o` in the first frame after enable. A failure to clear the counters on enable breaks the fixed alignment of `bclk_o` and `fsync_o` after the next enable edge. The bench compares both outputs against a behavioural model on every cycle, so any such difference is caught in the cycle it first appears.

// File: rtl/clkfs_pkg.sv
package clkfs_pkg;

  localparam int unsigned CLKFS_DIV_W = 20;

  typedef enum logic {
    BC_PASS   = 1'b0,
    BC_DIVIDE = 1'b1
  } bc_mode_e;

  typedef enum logic {
    FS_BYPASS = 1'b0,
    FS_DIVIDE = 1'b1
  } fs_mode_e;

endpackage

// File: rtl/clkfs_src_sample.sv
module clkfs_src_sample (
  input  logic clk,
  input  logic rst_n,
  input  logic src_clk,
  input  logic src_loop,
  output logic src_lvl_q,
  output logic src_tick
);

  logic lvl_d;

  // refused feedback request: the source is tied low, never to our own output
  always_comb begin
    lvl_d    = src_loop ? 1'b0 : src_clk;
    src_tick = lvl_d & ~src_lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_lvl_q <= 1'b0;
    end else begin
      src_lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/clkfs_bit_div.sv
module clkfs_bit_div
  import clkfs_pkg::*;
#(
  parameter int unsigned DIV_W = CLKFS_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_q,
  input  logic             tick,
  input  logic             src_lvl_q,
  input  logic [DIV_W-1:0] clk_div,
  output logic             bclk,
  output logic             bit_wrap
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  bc_mode_e         mode;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] half;
  logic             at_end;
  logic             cnt_en;

  always_comb begin
    mode   = (clk_div > ONE) ? BC_DIVIDE : BC_PASS;
    half   = clk_div >> 1;
    at_end = (cnt_q >= clk_div - ONE);
    cnt_en = run & tick & (mode == BC_DIVIDE);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run || mode == BC_PASS) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = at_end ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    bit_wrap = run & tick & ((mode == BC_PASS) | at_end);
    if (mode == BC_PASS) begin
      bclk = run_q & src_lvl_q;
    end else begin
      bclk = run_q & (cnt_q < half);
    end
  end

endmodule

// File: rtl/clkfs_frame_gen.sv
module clkfs_frame_gen
  import clkfs_pkg::*;
#(
  parameter int unsigned DIV_W = CLKFS_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             run_q,
  input  logic             bit_wrap,
  input  logic             fs_ext,
  input  logic [DIV_W-1:0] frm_div,
  input  logic [DIV_W-1:0] frm_phase,
  output logic             fsync
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  fs_mode_e         mode;
  logic [DIV_W-1:0] frm_q;
  logic [DIV_W-1:0] frm_d;
  logic [DIV_W-1:0] phase_eff;
  logic             ext_q;
  logic             ext_d;

  function automatic logic [DIV_W-1:0] phase_reduce(
    input logic [DIV_W-1:0] p,
    input logic [DIV_W-1:0] d
  );
    if (d > ONE) begin
      return p % d;
    end
    return '0;
  endfunction

  always_comb begin
    mode      = (frm_div > ONE) ? FS_DIVIDE : FS_BYPASS;
    phase_eff = phase_reduce(frm_phase, frm_div);
    ext_d     = fs_ext;
  end

  always_comb begin
    frm_d = frm_q;
    if (!run || mode == FS_BYPASS) begin
      frm_d = '0;
    end else if (bit_wrap) begin
      frm_d = (frm_q >= frm_div - ONE) ? '0 : frm_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q <= '0;
      ext_q <= 1'b0;
    end else begin
      frm_q <= frm_d;
      ext_q <= ext_d;
    end
  end

  always_comb begin
    if (mode == FS_BYPASS) begin
      fsync = run_q & ext_q;
    end else begin
      fsync = run_q & (frm_q == phase_eff);
    end
  end

endmodule

// File: rtl/clkfs_gen.sv
module clkfs_gen
  import clkfs_pkg::*;
#(
  parameter int unsigned DIV_W = CLKFS_DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             src_clk,
  input  logic             src_loop,
  input  logic             fs_ext,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [DIV_W-1:0] frm_div,
  input  logic [DIV_W-1:0] frm_phase,
  output logic             bclk_o,
  output logic             fsync_o
);

  logic en_q;
  logic src_lvl_q;
  logic src_tick;
  logic bit_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= enable;
    end
  end

  clkfs_src_sample u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_clk   (src_clk),
    .src_loop  (src_loop),
    .src_lvl_q (src_lvl_q),
    .src_tick  (src_tick)
  );

  clkfs_bit_div #(.DIV_W(DIV_W)) u_bit (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (enable),
    .run_q     (en_q),
    .tick      (src_tick),
    .src_lvl_q (src_lvl_q),
    .clk_div   (clk_div),
    .bclk      (bclk_o),
    .bit_wrap  (bit_wrap)
  );

  clkfs_frame_gen #(.DIV_W(DIV_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (enable),
    .run_q     (en_q),
    .bit_wrap  (bit_wrap),
    .fs_ext    (fs_ext),
    .frm_div   (frm_div),
    .frm_phase (frm_phase),
    .fsync     (fsync_o)
  );

endmodule

// File: rtl/clkfs_gen_chk.sv
module clkfs_gen_chk #(
  parameter int unsigned DIV_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             src_clk,
  input logic             src_loop,
  input logic             fs_ext,
  input logic [DIV_W-1:0] clk_div,
  input logic [DIV_W-1:0] frm_div,
  input logic [DIV_W-1:0] frm_phase,
  input logic             bclk_o,
  input logic             fsync_o,
  input logic             src_tick
);

  logic [1:0] live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 2'b00;
    end else begin
      live_q <= {live_q[0], 1'b1};
    end
  end

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[0] && !$past(enable) |-> (!bclk_o && !fsync_o));

  // R6
  fs_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[0] && $past(enable) && (frm_div < 2) |-> (fsync_o == $past(fs_ext)));

  // R3
  bclk_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[0] && $past(enable) && (clk_div < 2)
      |-> (bclk_o == $past(src_clk && !src_loop)));

  // R7
  loop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[0] && $past(src_loop) && (clk_div < 2) |-> !bclk_o);

  // R1
  bclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[1] && $past(enable) && $past(enable, 2) && (clk_div >= 2)
      && $stable(clk_div) && !$past(src_tick) |-> $stable(bclk_o));

  // R4
  fs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[0] && $rose(fsync_o) && (frm_div >= 2) && (clk_div >= 2)
      && $stable(frm_div) && $stable(frm_phase) && $stable(clk_div)
      |-> $rose(bclk_o));

endmodule

bind clkfs_gen clkfs_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .src_clk   (src_clk),
  .src_loop  (src_loop),
  .fs_ext    (fs_ext),
  .clk_div   (clk_div),
  .frm_div   (frm_div),
  .frm_phase (frm_phase),
  .bclk_o    (bclk_o),
  .fsync_o   (fsync_o),
  .src_tick  (src_tick)
);

// File: tb/clkfs_gen_bench.sv
`timescale 1ns/1ps
module clkfs_gen_bench;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        src_clk;
  logic        src_loop;
  logic        fs_ext;
  logic [19:0] clk_div;
  logic [19:0] frm_div;
  logic [19:0] frm_phase;
  logic        bclk_o;
  logic        fsync_o;

  clkfs_gen u_clkfs_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .src_clk   (src_clk),
    .src_loop  (src_loop),
    .fs_ext    (fs_ext),
    .clk_div   (clk_div),
    .frm_div   (frm_div),
    .frm_phase (frm_phase),
    .bclk_o    (bclk_o),
    .fsync_o   (fsync_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_vec  = 0;
  int    n_bad  = 0;
  string tag    = "R8";
  bit    done   = 0;
  int    src_half = 2;
  int    src_cnt  = 0;
  bit    pat_on   = 0;
  int    pat_cnt  = 0;
  bit    meas     = 0;
  int    hi_b     = 0;
  int    hi_f     = 0;

  // behavioural reference state
  int m_c, m_f;
  bit m_srcq, m_enq, m_fsq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c = 0; m_f = 0; m_srcq = 0; m_enq = 0; m_fsq = 0;
    end else begin
      bit lvl, tk, wrap;
      int d, f;
      d    = int'(clk_div);
      f    = int'(frm_div);
      lvl  = src_loop ? 1'b0 : src_clk;
      tk   = lvl && !m_srcq;
      wrap = 0;
      if (!enable) begin
        m_c = 0; m_f = 0;
      end else begin
        if (d < 2) begin
          m_c = 0;
          wrap = tk;
        end else if (tk) begin
          wrap = (m_c >= d - 1);
          m_c  = wrap ? 0 : m_c + 1;
        end
        if (f < 2) m_f = 0;
        else if (wrap) m_f = (m_f >= f - 1) ? 0 : m_f + 1;
      end
      m_srcq = lvl;
      m_enq  = enable;
      m_fsq  = fs_ext;
    end
  end

  // source clock and external frame pattern drivers
  always @(negedge clk) begin
    src_cnt = src_cnt + 1;
    if (src_cnt >= src_half) begin
      src_cnt = 0;
      src_clk = ~src_clk;
    end
    if (pat_on) begin
      pat_cnt = pat_cnt + 1;
      fs_ext  = ((pat_cnt % 7) < 3);
    end
  end

  // compare against the model on every cycle, clear of any edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit eb, ef;
      int d, f, ph;
      d  = int'(clk_div);
      f  = int'(frm_div);
      ph = (f >= 2) ? (int'(frm_phase) % f) : 0;
      eb = m_enq && ((d < 2) ? m_srcq : (m_c < d / 2));
      ef = m_enq && ((f < 2) ? m_fsq : (m_f == ph));
      n_vec++;
      if (bclk_o !== eb || fsync_o !== ef) begin
        n_bad++;
        $display("FAIL %s: bclk_o/fsync_o = %b%b expected %b%b at %0t",
                 tag, bclk_o, fsync_o, eb, ef, $time);
      end
      if (meas) begin
        hi_b += bclk_o;
        hi_f += fsync_o;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n, output int b, output int f);
    @(negedge clk);
    hi_b = 0; hi_f = 0; meas = 1;
    cycles(n);
    meas = 0;
    b = hi_b; f = hi_f;
  endtask

  task automatic start(input int d, input int f, input int p, input string t);
    @(negedge clk);
    enable = 0;
    cycles(3);
    tag = t;
    clk_div = 20'(d); frm_div = 20'(f); frm_phase = 20'(p);
    @(negedge clk);
    enable = 1;
  endtask

  task automatic summary;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
  end

  initial begin
    int b, f;
    rst_n = 0; enable = 0; src_clk = 0; src_loop = 0; fs_ext = 0;
    clk_div = 20'd4; frm_div = 20'd5; frm_phase = 20'd2;
    cycles(4);
    // R8: reset state
    check_eq("R8 reset bclk_o", int'(bclk_o), 0);
    check_eq("R8 reset fsync_o", int'(fsync_o), 0);
    @(negedge clk);
    rst_n = 1;

    // R1 R4: even divisor, phase inside range
    start(4, 5, 2, "R1/R4");
    cycles(100);
    measure(160, b, f);
    check_eq("R1 bclk high cycles", b, 80);
    check_eq("R4 fsync high cycles", f, 32);

    // R2: odd divisor duty
    start(5, 3, 0, "R2");
    cycles(60);
    measure(200, b, f);
    check_eq("R2 bclk high cycles", b, 80);

    // R5: phase beyond frame divisor
    start(4, 3, 7, "R5");
    cycles(60);
    measure(96, b, f);
    check_eq("R5 fsync high cycles", f, 32);

    // R3: bit clock pass-through
    start(1, 4, 3, "R3");
    cycles(40);
    measure(80, b, f);
    check_eq("R3 bclk high cycles", b, 40);
    start(0, 2, 1, "R3");
    cycles(40);

    // R6: frame bypass with an external pattern
    pat_on = 1;
    start(4, 0, 5, "R6");
    cycles(80);
    start(3, 1, 0, "R6");
    cycles(80);
    pat_on = 0;

    // R7: feedback request ties the source low
    start(0, 3, 0, "R7");
    src_loop = 1;
    cycles(5);
    measure(50, b, f);
    check_eq("R7 bclk high cycles", b, 0);
    start(4, 3, 1, "R7");
    cycles(50);
    src_loop = 0;
    cycles(40);

    // R8: disable mid-run, outputs low, then restart aligned
    start(6, 4, 0, "R8");
    cycles(70);
    enable = 0;
    cycles(2);
    measure(20, b, f);
    check_eq("R8 disabled bclk high", b, 0);
    check_eq("R8 disabled fsync high", f, 0);
    enable = 1;
    @(negedge clk);
    #1;
    check_eq("R8 bclk after enable", int'(bclk_o), 1);
    check_eq("R8 fsync after enable", int'(fsync_o), 1);
    cycles(100);

    summary();
  end

endmodule